// File: doc/BRIEF.md
# Shadow Memory Transfer Sequencer

This block pairs a byte-wide working RAM with a nonvolatile shadow array of equal size and moves whole images between them on command. A host reads and writes the working RAM through a simple single-cycle port. A store request first erases every shadow location and then programs the shadow array from the working RAM. A recall request first clears every working RAM location and then loads it from the shadow array; the shadow array is left as it was, so any number of recalls return the same image.

Each transfer walks the address space one location per clock in each of its two phases. A cycle counter then stretches the busy window to a fixed duration given in clock cycles, so the long programming time of real cells can be modelled with a short value in simulation. While busy, host reads and writes and new requests are dropped. A one-cycle done pulse marks the return to idle. The address width defaults to 10 bits to keep elaboration small; the full-size instance sets it to 13 (8192 bytes per array).

Top module: `shadow_xfer_seq`

## Requirements
- R1: While idle, a host write (`host_en`=1, `host_we`=1) stores `host_wdata` at `host_addr`, and a host read (`host_en`=1, `host_we`=0) places the byte at `host_addr` on `host_rdata` from the next clock edge on; `host_rdata` holds otherwise.
- R2: A store leaves the shadow array equal, at every address, to the working RAM contents at the start of the store; no byte of the earlier shadow image survives.
- R3: A recall replaces every working RAM byte with the shadow byte at the same address and never writes the shadow array; repeated recalls return the same image.
- R4: `busy` rises at the clock edge that samples an accepted request and stays high for exactly max(STORE_CYCLES, 2*2^ADDR_W) cycles for a store and max(RECALL_CYCLES, 2*2^ADDR_W) cycles for a recall.
- R5: Host writes presented while `busy` is high change no working RAM byte.
- R6: Host reads presented while `busy` is high leave `host_rdata` unchanged.
- R7: A store or recall request presented while `busy` is high is ignored: no further transfer follows the current one.
- R8: `done` is high for exactly one cycle, the first cycle in which `busy` is low after a transfer, and low at all other times.
- R9: When store and recall requests arrive in the same idle cycle, the store is performed and the recall is dropped.
- R10: A host write presented in the same idle cycle as a store request is accepted and is part of the stored image.
- R11: After reset `busy`, `done` and `host_rdata` are 0 and every byte of both arrays is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered host read data |
| store_req | input | 1 | Start a store (working RAM to shadow) |
| recall_req | input | 1 | Start a recall (shadow to working RAM) |
| busy | output | 1 | Transfer in progress, host locked out |
| done | output | 1 | One-cycle pulse on return to idle |

## Verification
Two pairs of functions can fall in one cycle: a host write together with a store request in the last idle cycle, and a store request together with a recall request. The first is provoked by driving the write strobe and the store request on the same edge to one address of an otherwise known image; after the store the working RAM is overwritten, a recall brings the shadow back, and the byte must read as the one written in the request cycle. The second is provoked by raising both requests together; the busy window must have the store length, and a later recall must return the image held at that moment rather than the earlier shadow.

// File: rtl/shadow_xfer_pkg.sv
package shadow_xfer_pkg;

    typedef enum logic [2:0] {
        XF_IDLE,
        XF_ERASE,
        XF_PROGRAM,
        XF_CLEAR,
        XF_LOAD,
        XF_HOLD
    } xfer_state_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/shadow_xfer_mem.sv
module shadow_xfer_mem #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= '0;
            end
        end else if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];

endmodule

// File: rtl/shadow_xfer_ctrl.sv
module shadow_xfer_ctrl
    import shadow_xfer_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int STORE_EFF = 4096,
    parameter int RECALL_EFF = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_req,
    input  logic              recall_req,
    output xfer_state_e       state_o,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int MAX_EFF = max_int(STORE_EFF, RECALL_EFF);
    localparam int CNT_W   = $clog2(MAX_EFF + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    typedef struct packed {
        xfer_state_e       state;
        logic              is_store;
        logic [ADDR_W-1:0] ptr;
        logic [CNT_W-1:0]  tick;
        logic              done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = ctrl_q.is_store ? CNT_W'(STORE_EFF) : CNT_W'(RECALL_EFF);
        ctrl_d = ctrl_q;
        ctrl_d.done = 1'b0;
        if (ctrl_q.state != XF_IDLE) begin
            ctrl_d.tick = ctrl_q.tick + 1'b1;
        end
        case (ctrl_q.state)
            XF_IDLE: begin
                if (store_req) begin
                    ctrl_d.state    = XF_ERASE;
                    ctrl_d.is_store = 1'b1;
                    ctrl_d.ptr      = '0;
                    ctrl_d.tick     = CNT_W'(1);
                end else if (recall_req) begin
                    ctrl_d.state    = XF_CLEAR;
                    ctrl_d.is_store = 1'b0;
                    ctrl_d.ptr      = '0;
                    ctrl_d.tick     = CNT_W'(1);
                end
            end
            XF_ERASE, XF_CLEAR: begin
                ctrl_d.ptr = ctrl_q.ptr + 1'b1;
                if (ctrl_q.ptr == LAST_ADDR) begin
                    ctrl_d.state = (ctrl_q.state == XF_ERASE) ? XF_PROGRAM : XF_LOAD;
                end
            end
            XF_PROGRAM, XF_LOAD: begin
                ctrl_d.ptr = ctrl_q.ptr + 1'b1;
                if (ctrl_q.ptr == LAST_ADDR) begin
                    if (ctrl_q.tick >= limit) begin
                        ctrl_d.state = XF_IDLE;
                        ctrl_d.done  = 1'b1;
                    end else begin
                        ctrl_d.state = XF_HOLD;
                    end
                end
            end
            XF_HOLD: begin
                if (ctrl_q.tick >= limit) begin
                    ctrl_d.state = XF_IDLE;
                    ctrl_d.done  = 1'b1;
                end
            end
            default: begin
                ctrl_d.state = XF_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: XF_IDLE, default: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign state_o = ctrl_q.state;
    assign ptr_o   = ctrl_q.ptr;
    assign busy_o  = (ctrl_q.state != XF_IDLE);
    assign done_o  = ctrl_q.done;

endmodule

// File: rtl/shadow_xfer_seq.sv
module shadow_xfer_seq
    import shadow_xfer_pkg::*;
#(
    parameter int ADDR_W        = 10,
    parameter int DATA_W        = 8,
    parameter int STORE_CYCLES  = 500000,
    parameter int RECALL_CYCLES = 1000,
    parameter logic [DATA_W-1:0] ERASE_VAL = '1,
    parameter logic [DATA_W-1:0] CLEAR_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              store_req,
    input  logic              recall_req,
    output logic              busy,
    output logic              done
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int STORE_EFF  = max_int(STORE_CYCLES, 2 * DEPTH);
    localparam int RECALL_EFF = max_int(RECALL_CYCLES, 2 * DEPTH);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } host_t;

    xfer_state_e       state;
    logic [ADDR_W-1:0] ptr;

    logic              work_we;
    logic [ADDR_W-1:0] work_waddr;
    logic [DATA_W-1:0] work_wdata;
    logic [ADDR_W-1:0] work_raddr;
    logic [DATA_W-1:0] work_rdata;

    logic              shadow_we;
    logic [DATA_W-1:0] shadow_wdata;
    logic [DATA_W-1:0] shadow_rdata;

    host_t host_d, host_q;

    shadow_xfer_ctrl #(
        .ADDR_W     (ADDR_W),
        .STORE_EFF  (STORE_EFF),
        .RECALL_EFF (RECALL_EFF)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .store_req  (store_req),
        .recall_req (recall_req),
        .state_o    (state),
        .ptr_o      (ptr),
        .busy_o     (busy),
        .done_o     (done)
    );

    always_comb begin
        work_we      = 1'b0;
        work_waddr   = host_addr;
        work_wdata   = host_wdata;
        shadow_we    = 1'b0;
        shadow_wdata = ERASE_VAL;
        work_raddr   = (state == XF_IDLE) ? host_addr : ptr;
        case (state)
            XF_IDLE: begin
                work_we = host_en & host_we;
            end
            XF_CLEAR: begin
                work_we    = 1'b1;
                work_waddr = ptr;
                work_wdata = CLEAR_VAL;
            end
            XF_LOAD: begin
                work_we    = 1'b1;
                work_waddr = ptr;
                work_wdata = shadow_rdata;
            end
            XF_ERASE: begin
                shadow_we    = 1'b1;
                shadow_wdata = ERASE_VAL;
            end
            XF_PROGRAM: begin
                shadow_we    = 1'b1;
                shadow_wdata = work_rdata;
            end
            default: begin
            end
        endcase
    end

    shadow_xfer_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_work (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (work_we),
        .waddr (work_waddr),
        .wdata (work_wdata),
        .raddr (work_raddr),
        .rdata (work_rdata)
    );

    shadow_xfer_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (shadow_we),
        .waddr (ptr),
        .wdata (shadow_wdata),
        .raddr (ptr),
        .rdata (shadow_rdata)
    );

    always_comb begin
        host_d = host_q;
        if (state == XF_IDLE && host_en && !host_we) begin
            host_d.rdata = work_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_q <= '0;
        end else begin
            host_q <= host_d;
        end
    end

    assign host_rdata = host_q.rdata;

endmodule

// File: rtl/shadow_xfer_chk.sv
module shadow_xfer_chk
    import shadow_xfer_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int STORE_EFF  = 4096,
    parameter int RECALL_EFF = 2048
) (
    input logic              clk,
    input logic              rst_n,
    input logic              store_req,
    input logic              recall_req,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] host_rdata,
    input xfer_state_e       state,
    input logic              shadow_we
);
    localparam int MAX_EFF = max_int(STORE_EFF, RECALL_EFF);
    localparam int RUN_W   = $clog2(MAX_EFF + 2);

    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (store_req || recall_req)) |=> busy);

    assert_busy_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < RUN_W'(MAX_EFF)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(host_rdata));

    assert_shadow_untouched_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == XF_CLEAR || state == XF_LOAD) |-> !shadow_we);

    assert_store_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == XF_IDLE && store_req) |=> (state == XF_ERASE));

endmodule

bind shadow_xfer_seq shadow_xfer_chk #(
    .DATA_W     (DATA_W),
    .STORE_EFF  (STORE_EFF),
    .RECALL_EFF (RECALL_EFF)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .store_req  (store_req),
    .recall_req (recall_req),
    .busy       (busy),
    .done       (done),
    .host_rdata (host_rdata),
    .state      (state),
    .shadow_we  (shadow_we)
);

// File: tb/shadow_xfer_seq_test.sv
module shadow_xfer_seq_test;
    localparam int AW     = 4;
    localparam int DW     = 8;
    localparam int DEPTH  = 1 << AW;
    localparam int ST_CYC = 60;
    localparam int RC_CYC = 40;
    localparam int ST_EXP = (ST_CYC > 2 * DEPTH) ? ST_CYC : 2 * DEPTH;
    localparam int RC_EXP = (RC_CYC > 2 * DEPTH) ? RC_CYC : 2 * DEPTH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_en = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          store_req = 1'b0;
    logic          recall_req = 1'b0;
    logic          busy;
    logic          done;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    shadow_xfer_seq #(
        .ADDR_W        (AW),
        .DATA_W        (DW),
        .STORE_CYCLES  (ST_CYC),
        .RECALL_CYCLES (RC_CYC)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_en    (host_en),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .store_req  (store_req),
        .recall_req (recall_req),
        .busy       (busy),
        .done       (done)
    );

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] pat_f(input int a);
        return DW'((a * 37 + 5) % 256);
    endfunction
    function automatic logic [DW-1:0] pat_g(input int a);
        return DW'(a ^ 8'hA5);
    endfunction
    function automatic logic [DW-1:0] pat_h(input int a);
        return DW'((a * 11 + 64) % 256);
    endfunction
    function automatic logic [DW-1:0] pat_k(input int a);
        return DW'(255 - a);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [DW-1:0] v);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_addr = AW'(a); host_wdata = v;
        @(posedge clk);
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_read(input int a, output logic [DW-1:0] v);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b0; host_addr = AW'(a);
        @(posedge clk);
        @(negedge clk);
        host_en = 1'b0;
        v = host_rdata;
    endtask

    task automatic fill(input int which);
        for (int a = 0; a < DEPTH; a++) begin
            case (which)
                0: host_write(a, pat_f(a));
                1: host_write(a, pat_g(a));
                2: host_write(a, pat_h(a));
                default: host_write(a, pat_k(a));
            endcase
        end
    endtask

    task automatic expect_image(input string tag, input int which, input int sp_addr, input int sp_val);
        logic [DW-1:0] v;
        int bad;
        int first_act;
        int first_exp;
        int e;
        bad = 0; first_act = 0; first_exp = 0;
        for (int a = 0; a < DEPTH; a++) begin
            host_read(a, v);
            case (which)
                0: e = pat_f(a);
                1: e = pat_g(a);
                2: e = pat_h(a);
                3: e = pat_k(a);
                default: e = 0;
            endcase
            if (a == sp_addr) e = sp_val;
            if (int'(v) != e && bad == 0) begin
                first_act = v; first_exp = e;
            end
            if (int'(v) != e) bad++;
        end
        chk(tag, first_act, first_exp);
    endtask

    task automatic run_xfer(input string tag, input bit st, input bit rc, input int exp_len);
        int len;
        @(negedge clk);
        store_req = st; recall_req = rc;
        @(posedge clk);
        @(negedge clk);
        store_req = 1'b0; recall_req = 1'b0;
        len = 0;
        while (busy && len < 1000) begin
            if (done) chk({tag, " R8 done low while busy"}, 1, 0);
            len++;
            @(negedge clk);
        end
        chk({tag, " R4 busy length"}, len, exp_len);
        chk({tag, " R8 done in first idle cycle"}, int'(done), 1);
        @(negedge clk);
        chk({tag, " R8 done one cycle"}, int'(done), 0);
    endtask

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 busy after reset", int'(busy), 0);
        chk("R11 done after reset", int'(done), 0);
        chk("R11 rdata after reset", int'(host_rdata), 0);
        expect_image("R11 working RAM zero", 4, -1, 0);

        fill(0);
        expect_image("R1 write/read pattern f", 0, -1, 0);

        run_xfer("R2 store f", 1'b1, 1'b0, ST_EXP);
        fill(1);
        expect_image("R1 write/read pattern g", 1, -1, 0);

        run_xfer("R3 recall", 1'b0, 1'b1, RC_EXP);
        expect_image("R3 recall returns f", 0, -1, 0);
        run_xfer("R3 second recall", 1'b0, 1'b1, RC_EXP);
        expect_image("R3 repeated recall returns f", 0, -1, 0);

        host_read(15, held);
        @(negedge clk);
        store_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        store_req = 1'b0;
        host_en = 1'b1; host_we = 1'b1; host_addr = AW'(3); host_wdata = 8'hEE;
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0; host_addr = AW'(7);
        @(posedge clk);
        @(negedge clk);
        host_en = 1'b0;
        chk("R6 rdata held during busy", int'(host_rdata), int'(held));
        recall_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        recall_req = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) begin
            @(negedge clk);
            chk("R7 request during busy ignored", int'(busy), 0);
        end
        host_read(3, v);
        chk("R5 write during busy ignored", int'(v), int'(pat_f(3)));

        fill(2);
        @(negedge clk);
        store_req = 1'b1;
        host_en = 1'b1; host_we = 1'b1; host_addr = AW'(9); host_wdata = 8'h3C;
        @(posedge clk);
        @(negedge clk);
        store_req = 1'b0; host_en = 1'b0; host_we = 1'b0;
        while (busy) @(negedge clk);
        fill(1);
        run_xfer("R10 recall after joint cycle", 1'b0, 1'b1, RC_EXP);
        expect_image("R10 write in request cycle stored, R2 old image erased", 2, 9, 8'h3C);

        fill(3);
        run_xfer("R9 both requests", 1'b1, 1'b1, ST_EXP);
        expect_image("R9 work unchanged by store", 3, -1, 0);
        fill(1);
        run_xfer("R9 recall check", 1'b0, 1'b1, RC_EXP);
        expect_image("R9 store won", 3, -1, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule